// File: doc/BRIEF.md
# General Purpose Register File with Pointer Pairs

This block is the working register store of a small 8-bit RISC core. It holds 32 byte-wide registers. An ALU instruction reads two operands through two combinational read ports and writes its result through one synchronous write port, all in the same clock. Reads show only the registered state. A value written on an edge is visible to the read ports after that edge.

The six highest-numbered working registers used for addressing are also seen as three 16-bit pointers. Pointer 0 is R27:R26, pointer 1 is R29:R28 and pointer 2 is R31:R30, with the low byte at the even index. Each pointer can be read as one word and written as one word in a single clock, which is how post-increment and pre-decrement address updates land. Pointer 2 also addresses constant tables in program memory, so it is driven on a dedicated output at all times.

The whole file is also mapped into the data address space at addresses 0x00 to 0x1F. Loads and stores there reach the registers. Any access at a higher address is flagged as not belonging to the file, and the file leaves it alone. Several write sources can hit the same byte in one clock. A fixed per-byte priority settles each such conflict.

Top module: `gpr_file`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears every register to 0x00.
- R2: rd_a_data and rd_b_data show, without a clock, the registers selected by rd_a_idx and rd_b_idx, and both ports may select any registers, including the same one. With wr_en high, wr_data is stored into register wr_idx at the rising edge.
- R3: The read ports do not forward write data. In the cycle a register is being written, a read of that register returns its old value.
- R4: The pointer select code 0 maps to {R27,R26}, code 1 to {R29,R28} and code 2 to {R31,R30}, with the odd register in bits 15:8. ptr_rd_data shows the selected pair combinationally.
- R5: With ptr_wr_en high, ptr_wr_data is written into both bytes of the pair named by ptr_wr_sel at one rising edge.
- R6: zptr always shows {R31,R30}, including the value written by the previous edge.
- R7: A data-space store (ds_wr) at address 0x0000 to 0x001F writes register ds_addr[4:0]. ds_rdata shows that register while ds_rd is high and the address is in that range. Otherwise ds_rdata is 0x00.
- R8: A data-space store and an ALU write to the same register in one clock leave the data-space value. If they target different registers, both writes land.
- R9: Priority is decided per byte, in the order data-space store, then ALU write, then pointer write. A pointer write still updates the byte of its pair that no higher source targets.
- R10: A data-space access (ds_rd or ds_wr) at address 0x0020 or above raises ds_not_reg in the same cycle, changes no register and returns ds_rdata of 0x00.
- R11: Pointer select code 3 names no pointer. A pointer write with it changes no register, and a pointer read with it returns 0x0000.
- R12: ds_not_reg stays low in every cycle in which neither ds_rd nor ds_wr is high, whatever the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Register index for read port A |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Register index for read port B |
| rd_b_data | output | 8 | Read port B data |
| wr_en | input | 1 | ALU result write enable |
| wr_idx | input | 5 | ALU result register index |
| wr_data | input | 8 | ALU result data |
| ptr_rd_sel | input | 2 | Pointer select for ptr_rd_data |
| ptr_rd_data | output | 16 | Selected pointer word |
| ptr_wr_en | input | 1 | Pointer word write enable |
| ptr_wr_sel | input | 2 | Pointer select for the word write |
| ptr_wr_data | input | 16 | Pointer word write data |
| zptr | output | 16 | Table-lookup pointer, always {R31,R30} |
| ds_addr | input | 16 | Data-space address |
| ds_rd | input | 1 | Data-space load strobe |
| ds_wr | input | 1 | Data-space store strobe |
| ds_wdata | input | 8 | Data-space store data |
| ds_rdata | output | 8 | Data-space load data from the file |
| ds_not_reg | output | 1 | Access is outside the register window |

## Verification
Several properties are checked in every cycle. Reads are cleared after reset. An uncontested ALU write and an uncontested pointer write become visible after the edge. A data-space store wins when it hits the same byte as another source. A read port holds its value while nothing writes the register it selects, which is what catches forwarding. zptr matches the pointer 2 read view. The out-of-window flag behaves as stated, and code 3 reads as zero. The per-byte merge of a pointer write with a byte write in its pair, and the address aliasing that a bad decode would cause (0x20, 0x100 and 0xFFFF landing on a register), are shown only by the bench's directed scenarios, which read the registers back afterwards.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
   // Symbolic pointer select codes used at the default configuration.
   typedef enum logic [1:0] {
      PTR_X    = 2'd0,
      PTR_Y    = 2'd1,
      PTR_Z    = 2'd2,
      PTR_NONE = 2'd3
   } ptr_sel_e;

   localparam int unsigned GPR_DEF_REGS   = 32;
   localparam int unsigned GPR_DEF_WIDTH  = 8;
   localparam int unsigned GPR_DEF_DS_W   = 16;
   localparam int unsigned GPR_DEF_PBASE  = 26;
   localparam int unsigned GPR_DEF_NPTRS  = 3;

   // Index of the low byte of pointer p.
   function automatic int unsigned pair_low(int unsigned base, int unsigned p);
      return base + 2 * p;
   endfunction
endpackage

// File: rtl/gpr_ds_decode.sv
module gpr_ds_decode #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned NUM_REGS = 32,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   output logic              rd_hit,
   output logic              wr_hit,
   output logic              not_reg,
   output logic [IDX_W-1:0]  idx
);
   localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);

   if (NUM_REGS >= (1 << ADDR_W)) begin : g_bad_window
      $error("register window does not fit the data address width");
   end

   logic in_file;

   always_comb begin
      in_file = (addr < LIMIT);
      rd_hit  = rd & in_file;
      wr_hit  = wr & in_file;
      not_reg = (rd | wr) & ~in_file;
      idx     = addr[IDX_W-1:0];
   end
endmodule

// File: rtl/gpr_read_mux.sv
module gpr_read_mux #(
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned DATA_W   = 8,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
   input  logic [IDX_W-1:0]                idx,
   output logic [DATA_W-1:0]               data
);
   if ((1 << IDX_W) == NUM_REGS) begin : g_pow2
      assign data = regs[idx];
   end else begin : g_guarded
      localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_REGS - 1);
      always_comb begin
         data = '0;
         if (idx <= TOP) data = regs[idx];
      end
   end
endmodule

// File: rtl/gpr_cell_array.sv
module gpr_cell_array #(
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned PTR_BASE = 26,
   parameter int unsigned NUM_PTRS = 3,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS),
   localparam int unsigned SEL_W   = $clog2(NUM_PTRS + 1)
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            alu_we,
   input  logic [IDX_W-1:0]                alu_idx,
   input  logic [DATA_W-1:0]               alu_data,
   input  logic                            ds_we,
   input  logic [IDX_W-1:0]                ds_idx,
   input  logic [DATA_W-1:0]               ds_data,
   input  logic                            ptr_we,
   input  logic [SEL_W-1:0]                ptr_sel,
   input  logic [2*DATA_W-1:0]             ptr_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0] regs
);
   localparam int unsigned PTR_END = PTR_BASE + 2 * NUM_PTRS;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] d;
      logic              we;
      logic              ptr_hit;
      logic [DATA_W-1:0] ptr_byte;

      if (i >= PTR_BASE && i < PTR_END) begin : g_paired
         localparam int unsigned PIDX = (i - PTR_BASE) / 2;
         localparam bit          HIGH = ((i - PTR_BASE) % 2) == 1;
         assign ptr_hit  = ptr_we && (ptr_sel == SEL_W'(PIDX));
         assign ptr_byte = HIGH ? ptr_data[2*DATA_W-1:DATA_W] : ptr_data[DATA_W-1:0];
      end else begin : g_plain
         assign ptr_hit  = 1'b0;
         assign ptr_byte = '0;
      end

      // Lowest priority first; later assignments override.
      always_comb begin
         we = 1'b0;
         d  = '0;
         if (ptr_hit) begin
            we = 1'b1;
            d  = ptr_byte;
         end
         if (alu_we && alu_idx == IDX_W'(i)) begin
            we = 1'b1;
            d  = alu_data;
         end
         if (ds_we && ds_idx == IDX_W'(i)) begin
            we = 1'b1;
            d  = ds_data;
         end
      end

      always_ff @(posedge clk) begin
         if (rst)     q <= '0;
         else if (we) q <= d;
      end

      assign regs[i] = q;
   end
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
   parameter int unsigned NUM_REGS  = gpr_pkg::GPR_DEF_REGS,
   parameter int unsigned DATA_W    = gpr_pkg::GPR_DEF_WIDTH,
   parameter int unsigned DS_ADDR_W = gpr_pkg::GPR_DEF_DS_W,
   parameter int unsigned PTR_BASE  = gpr_pkg::GPR_DEF_PBASE,
   parameter int unsigned NUM_PTRS  = gpr_pkg::GPR_DEF_NPTRS,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS),
   localparam int unsigned SEL_W    = $clog2(NUM_PTRS + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [IDX_W-1:0]     rd_a_idx,
   output logic [DATA_W-1:0]    rd_a_data,
   input  logic [IDX_W-1:0]     rd_b_idx,
   output logic [DATA_W-1:0]    rd_b_data,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [SEL_W-1:0]     ptr_rd_sel,
   output logic [2*DATA_W-1:0]  ptr_rd_data,
   input  logic                 ptr_wr_en,
   input  logic [SEL_W-1:0]     ptr_wr_sel,
   input  logic [2*DATA_W-1:0]  ptr_wr_data,
   output logic [2*DATA_W-1:0]  zptr,
   input  logic [DS_ADDR_W-1:0] ds_addr,
   input  logic                 ds_rd,
   input  logic                 ds_wr,
   input  logic [DATA_W-1:0]    ds_wdata,
   output logic [DATA_W-1:0]    ds_rdata,
   output logic                 ds_not_reg
);
   localparam int unsigned SEL_CODES = 1 << SEL_W;

   // Elaboration-time parameter checks.
   if (NUM_REGS < 2) begin : g_chk_regs
      $error("NUM_REGS must be at least 2");
   end
   if (NUM_PTRS < 1) begin : g_chk_nptr
      $error("NUM_PTRS must be at least 1");
   end
   if (PTR_BASE % 2 != 0) begin : g_chk_align
      $error("PTR_BASE must be even");
   end
   if (gpr_pkg::pair_low(PTR_BASE, NUM_PTRS) > NUM_REGS) begin : g_chk_fit
      $error("pointer pairs exceed the register file");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] regs;
   logic                            ds_rd_hit;
   logic                            ds_wr_hit;
   logic [IDX_W-1:0]                ds_idx;
   logic [DATA_W-1:0]               ds_mux;

   gpr_ds_decode #(.ADDR_W(DS_ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
      .addr    (ds_addr),
      .rd      (ds_rd),
      .wr      (ds_wr),
      .rd_hit  (ds_rd_hit),
      .wr_hit  (ds_wr_hit),
      .not_reg (ds_not_reg),
      .idx     (ds_idx)
   );

   gpr_cell_array #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .PTR_BASE (PTR_BASE),
      .NUM_PTRS (NUM_PTRS)
   ) u_cells (
      .clk      (clk),
      .rst      (rst),
      .alu_we   (wr_en),
      .alu_idx  (wr_idx),
      .alu_data (wr_data),
      .ds_we    (ds_wr_hit),
      .ds_idx   (ds_idx),
      .ds_data  (ds_wdata),
      .ptr_we   (ptr_wr_en),
      .ptr_sel  (ptr_wr_sel),
      .ptr_data (ptr_wr_data),
      .regs     (regs)
   );

   gpr_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_a (
      .regs (regs), .idx (rd_a_idx), .data (rd_a_data)
   );
   gpr_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_b (
      .regs (regs), .idx (rd_b_idx), .data (rd_b_data)
   );
   gpr_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_ds (
      .regs (regs), .idx (ds_idx), .data (ds_mux)
   );

   assign ds_rdata = ds_rd_hit ? ds_mux : '0;

   // Pointer word view; unused select codes read as zero.
   logic [2*DATA_W-1:0] ptr_words [SEL_CODES];

   for (genvar p = 0; p < SEL_CODES; p++) begin : g_pword
      if (p < NUM_PTRS) begin : g_live
         localparam int unsigned LO = gpr_pkg::pair_low(PTR_BASE, p);
         assign ptr_words[p] = {regs[LO+1], regs[LO]};
      end else begin : g_dead
         assign ptr_words[p] = '0;
      end
   end

   assign ptr_rd_data = ptr_words[ptr_rd_sel];
   assign zptr        = ptr_words[NUM_PTRS-1];
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
   parameter int unsigned NUM_REGS  = 32,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned DS_ADDR_W = 16,
   parameter int unsigned PTR_BASE  = 26,
   parameter int unsigned NUM_PTRS  = 3,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS),
   localparam int unsigned SEL_W    = $clog2(NUM_PTRS + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [IDX_W-1:0]     rd_a_idx,
   input  logic [DATA_W-1:0]    rd_a_data,
   input  logic [DATA_W-1:0]    rd_b_data,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [SEL_W-1:0]     ptr_rd_sel,
   input  logic [2*DATA_W-1:0]  ptr_rd_data,
   input  logic                 ptr_wr_en,
   input  logic [SEL_W-1:0]     ptr_wr_sel,
   input  logic [2*DATA_W-1:0]  ptr_wr_data,
   input  logic [2*DATA_W-1:0]  zptr,
   input  logic [DS_ADDR_W-1:0] ds_addr,
   input  logic                 ds_rd,
   input  logic                 ds_wr,
   input  logic [DATA_W-1:0]    ds_wdata,
   input  logic [DATA_W-1:0]    ds_rdata,
   input  logic                 ds_not_reg
);
   localparam logic [SEL_W-1:0]     NP    = SEL_W'(NUM_PTRS);
   localparam logic [SEL_W-1:0]     ZSEL  = SEL_W'(NUM_PTRS - 1);
   localparam logic [DS_ADDR_W-1:0] LIMIT = DS_ADDR_W'(NUM_REGS);
   localparam int unsigned          PEND  = PTR_BASE + 2 * NUM_PTRS;

   logic ds_in;
   logic alu_solo;
   logic touch_a;
   logic ptr_solo;

   always_comb begin
      int unsigned ai;
      int unsigned wi;
      int unsigned di;
      int unsigned ps;
      ai = int'(rd_a_idx);
      wi = int'(wr_idx);
      di = int'(ds_addr);
      ps = int'(ptr_wr_sel);
      ds_in    = ds_addr < LIMIT;
      alu_solo = wr_en && !(ds_wr && ds_addr == DS_ADDR_W'(wr_idx));
      touch_a  = (wr_en && wr_idx == rd_a_idx)
              || (ds_wr && ds_addr == DS_ADDR_W'(rd_a_idx))
              || (ptr_wr_en && ptr_wr_sel < NP && ai >= PTR_BASE && ai < PEND
                  && (ai - PTR_BASE) / 2 == ps);
      ptr_solo = ptr_wr_en && ptr_wr_sel < NP
              && !(wr_en && wi >= PTR_BASE && wi < PEND && (wi - PTR_BASE) / 2 == ps)
              && !(ds_wr && ds_in && di >= PTR_BASE && di < PEND && (di - PTR_BASE) / 2 == ps);
   end

   // R1: registers read as zero right after reset
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0 && zptr == '0));

   // R2: an uncontested ALU write is visible after the edge
   p_alu_write_r2: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst && alu_solo) && rd_a_idx == $past(wr_idx))
      |-> rd_a_data == $past(wr_data));

   // R3: read data moves only when the selected register was written
   p_no_forward_r3: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst && !touch_a) && $stable(rd_a_idx)) |-> $stable(rd_a_data));

   // R5: an uncontested pointer write lands as one word
   p_ptr_word_r5: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst && ptr_solo) && ptr_rd_sel == $past(ptr_wr_sel))
      |-> ptr_rd_data == $past(ptr_wr_data));

   // R6: table pointer output matches the pointer 2 view
   p_zptr_view_r6: assert property (@(posedge clk) disable iff (rst)
      (ptr_rd_sel == ZSEL) |-> zptr == ptr_rd_data);

   // R8: a data-space store wins on its register
   p_ds_wins_r8: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst && ds_wr && ds_in) && ds_rd && ds_addr == $past(ds_addr))
      |-> ds_rdata == $past(ds_wdata));

   // R10: an out-of-window access returns nothing
   p_outside_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      ds_not_reg |-> ds_rdata == '0);

   // R11: an unused pointer code reads as zero
   p_dead_sel_r11: assert property (@(posedge clk) disable iff (rst)
      (ptr_rd_sel >= NP) |-> ptr_rd_data == '0);

   // R12: no flag without an access
   p_flag_idle_r12: assert property (@(posedge clk) disable iff (rst)
      !(ds_rd || ds_wr) |-> !ds_not_reg);
endmodule

bind gpr_file gpr_file_chk #(
   .NUM_REGS  (NUM_REGS),
   .DATA_W    (DATA_W),
   .DS_ADDR_W (DS_ADDR_W),
   .PTR_BASE  (PTR_BASE),
   .NUM_PTRS  (NUM_PTRS)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .rd_a_idx    (rd_a_idx),
   .rd_a_data   (rd_a_data),
   .rd_b_data   (rd_b_data),
   .wr_en       (wr_en),
   .wr_idx      (wr_idx),
   .wr_data     (wr_data),
   .ptr_rd_sel  (ptr_rd_sel),
   .ptr_rd_data (ptr_rd_data),
   .ptr_wr_en   (ptr_wr_en),
   .ptr_wr_sel  (ptr_wr_sel),
   .ptr_wr_data (ptr_wr_data),
   .zptr        (zptr),
   .ds_addr     (ds_addr),
   .ds_rd       (ds_rd),
   .ds_wr       (ds_wr),
   .ds_wdata    (ds_wdata),
   .ds_rdata    (ds_rdata),
   .ds_not_reg  (ds_not_reg)
);

// File: tb/sim_gpr_file.sv
module sim_gpr_file;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  rd_a_idx = '0;
   logic [7:0]  rd_a_data;
   logic [4:0]  rd_b_idx = '0;
   logic [7:0]  rd_b_data;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic [7:0]  wr_data = '0;
   logic [1:0]  ptr_rd_sel = '0;
   logic [15:0] ptr_rd_data;
   logic        ptr_wr_en = 1'b0;
   logic [1:0]  ptr_wr_sel = '0;
   logic [15:0] ptr_wr_data = '0;
   logic [15:0] zptr;
   logic [15:0] ds_addr = '0;
   logic        ds_rd = 1'b0;
   logic        ds_wr = 1'b0;
   logic [7:0]  ds_wdata = '0;
   logic [7:0]  ds_rdata;
   logic        ds_not_reg;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   gpr_file u0 (
      .clk(clk), .rst(rst),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .ptr_rd_sel(ptr_rd_sel), .ptr_rd_data(ptr_rd_data),
      .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel), .ptr_wr_data(ptr_wr_data),
      .zptr(zptr),
      .ds_addr(ds_addr), .ds_rd(ds_rd), .ds_wr(ds_wr),
      .ds_wdata(ds_wdata), .ds_rdata(ds_rdata), .ds_not_reg(ds_not_reg)
   );

   // Vector: [13] store through data space, [12:8] register, [7:0] value
   localparam logic [13:0] VEC [8] = '{
      {1'b0, 5'd0,  8'hA5}, {1'b0, 5'd31, 8'h5A}, {1'b1, 5'd7,  8'hC3},
      {1'b0, 5'd13, 8'h01}, {1'b1, 5'd19, 8'hFE}, {1'b0, 5'd26, 8'h80},
      {1'b1, 5'd27, 8'h7F}, {1'b0, 5'd1,  8'h3C}
   };

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic quiet();
      wr_en = 1'b0; ptr_wr_en = 1'b0; ds_wr = 1'b0; ds_rd = 1'b0;
   endtask

   task automatic step();
      @(negedge clk);
      quiet();
      #1;
   endtask

   task automatic rd_reg(input logic [4:0] i, output logic [7:0] v);
      rd_a_idx = i;
      #1;
      v = rd_a_data;
   endtask

   task automatic rd_ptr(input logic [1:0] s, output logic [15:0] v);
      ptr_rd_sel = s;
      #1;
      v = ptr_rd_data;
   endtask

   task automatic alu_put(input logic [4:0] i, input logic [7:0] d);
      wr_en = 1'b1; wr_idx = i; wr_data = d;
      step();
   endtask

   task automatic ds_put(input logic [15:0] a, input logic [7:0] d);
      ds_wr = 1'b1; ds_addr = a; ds_wdata = d;
      step();
   endtask

   initial begin
      logic [7:0]  v;
      logic [15:0] w;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;

      // R1: every register clears
      for (int i = 0; i < 32; i++) begin
         rd_a_idx = 5'(i); rd_b_idx = 5'(31 - i);
         #1;
         chk("R1 port A after reset", {8'h00, rd_a_data}, 16'h0000);
         chk("R1 port B after reset", {8'h00, rd_b_data}, 16'h0000);
      end

      // Vector walk: R2 ALU writes, R7 data-space stores and loads
      for (int k = 0; k < 8; k++) begin
         if (VEC[k][13]) ds_put({11'd0, VEC[k][12:8]}, VEC[k][7:0]);
         else            alu_put(VEC[k][12:8], VEC[k][7:0]);
         rd_a_idx = VEC[k][12:8]; rd_b_idx = VEC[k][12:8];
         ds_rd = 1'b1; ds_addr = {11'd0, VEC[k][12:8]};
         #1;
         chk("R2 port A readback", {8'h00, rd_a_data}, {8'h00, VEC[k][7:0]});
         chk("R2 port B same register", {8'h00, rd_b_data}, {8'h00, VEC[k][7:0]});
         chk("R7 data-space load", {8'h00, ds_rdata}, {8'h00, VEC[k][7:0]});
         ds_rd = 1'b0;
      end

      // R2: two different registers at once
      rd_a_idx = 5'd0; rd_b_idx = 5'd31;
      #1;
      chk("R2 dual read A", {8'h00, rd_a_data}, 16'h00A5);
      chk("R2 dual read B", {8'h00, rd_b_data}, 16'h005A);

      // R3: no forwarding in the write cycle
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'd5; wr_data = 8'h3C; rd_a_idx = 5'd5;
      #1;
      chk("R3 old value during write", {8'h00, rd_a_data}, 16'h0000);
      step();
      chk("R3 new value after edge", {8'h00, rd_a_data}, 16'h003C);

      // R4: pointer mapping
      alu_put(5'd26, 8'h34); alu_put(5'd27, 8'h12);
      ds_put(16'd28, 8'h78);  ds_put(16'd29, 8'h56);
      alu_put(5'd30, 8'hBC); ds_put(16'd31, 8'h9A);
      rd_ptr(2'd0, w); chk("R4 pointer 0 is R27:R26", w, 16'h1234);
      rd_ptr(2'd1, w); chk("R4 pointer 1 is R29:R28", w, 16'h5678);
      rd_ptr(2'd2, w); chk("R4 pointer 2 is R31:R30", w, 16'h9ABC);
      chk("R6 zptr view", zptr, 16'h9ABC);

      // R5: word write into pointer 1
      @(negedge clk);
      ptr_wr_en = 1'b1; ptr_wr_sel = 2'd1; ptr_wr_data = 16'hBEEF;
      step();
      rd_reg(5'd28, v); chk("R5 low byte", {8'h00, v}, 16'h00EF);
      rd_reg(5'd29, v); chk("R5 high byte", {8'h00, v}, 16'h00BE);
      rd_ptr(2'd1, w); chk("R5 word view", w, 16'hBEEF);

      // R6: zptr follows a pointer 2 write
      @(negedge clk);
      ptr_wr_en = 1'b1; ptr_wr_sel = 2'd2; ptr_wr_data = 16'hCAFE;
      #1;
      chk("R6 zptr before edge", zptr, 16'h9ABC);
      step();
      chk("R6 zptr after edge", zptr, 16'hCAFE);

      // R8: same register, data space wins; different registers, both land
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'd7; wr_data = 8'hAA;
      ds_wr = 1'b1; ds_addr = 16'd7; ds_wdata = 8'h55;
      step();
      rd_reg(5'd7, v); chk("R8 data space wins", {8'h00, v}, 16'h0055);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'd8; wr_data = 8'h11;
      ds_wr = 1'b1; ds_addr = 16'd9; ds_wdata = 8'h22;
      step();
      rd_reg(5'd8, v); chk("R8 ALU target written", {8'h00, v}, 16'h0011);
      rd_reg(5'd9, v); chk("R8 store target written", {8'h00, v}, 16'h0022);

      // R9: per-byte merge
      @(negedge clk);
      ptr_wr_en = 1'b1; ptr_wr_sel = 2'd0; ptr_wr_data = 16'h1111;
      wr_en = 1'b1; wr_idx = 5'd27; wr_data = 8'h22;
      step();
      rd_ptr(2'd0, w); chk("R9 ALU over pointer high byte", w, 16'h2211);
      @(negedge clk);
      ptr_wr_en = 1'b1; ptr_wr_sel = 2'd0; ptr_wr_data = 16'h3333;
      wr_en = 1'b1; wr_idx = 5'd26; wr_data = 8'h55;
      ds_wr = 1'b1; ds_addr = 16'd26; ds_wdata = 8'h44;
      step();
      rd_ptr(2'd0, w); chk("R9 store over ALU over pointer", w, 16'h3344);

      // R10: outside the window
      @(negedge clk);
      ds_wr = 1'b1; ds_addr = 16'h0020; ds_wdata = 8'hFF;
      #1;
      chk("R10 flag on store 0x20", {15'd0, ds_not_reg}, 16'h0001);
      step();
      rd_reg(5'd0, v); chk("R10 R0 untouched by 0x20", {8'h00, v}, 16'h00A5);
      ds_put(16'h0100, 8'hEE);
      rd_reg(5'd0, v); chk("R10 R0 untouched by 0x100", {8'h00, v}, 16'h00A5);
      ds_put(16'hFFFF, 8'h00);
      rd_reg(5'd31, v); chk("R10 R31 untouched by 0xFFFF", {8'h00, v}, 16'h00CA);
      @(negedge clk);
      ds_rd = 1'b1; ds_addr = 16'h0045;
      #1;
      chk("R10 flag on load", {15'd0, ds_not_reg}, 16'h0001);
      chk("R10 load returns zero", {8'h00, ds_rdata}, 16'h0000);
      step();

      // R11: unused pointer code
      @(negedge clk);
      ptr_wr_en = 1'b1; ptr_wr_sel = 2'd3; ptr_wr_data = 16'h0000;
      step();
      rd_ptr(2'd0, w); chk("R11 pointer 0 kept", w, 16'h3344);
      rd_ptr(2'd1, w); chk("R11 pointer 1 kept", w, 16'hBEEF);
      rd_ptr(2'd2, w); chk("R11 pointer 2 kept", w, 16'hCAFE);
      rd_ptr(2'd3, w); chk("R11 code 3 reads zero", w, 16'h0000);

      // R12 and R7: no access, no flag, no data
      ds_addr = 16'h0080;
      #1;
      chk("R12 flag idle", {15'd0, ds_not_reg}, 16'h0000);
      ds_addr = 16'h0007;
      #1;
      chk("R7 no load, zero data", {8'h00, ds_rdata}, 16'h0000);

      // R1: reset mid-run
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R1 zptr after second reset", zptr, 16'h0000);
      rd_ptr(2'd0, w); chk("R1 pointer 0 after second reset", w, 16'h0000);
      rd_reg(5'd0, v); chk("R1 R0 after second reset", {8'h00, v}, 16'h0000);

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule